// File: doc/BRIEF.md
# Pipelined Permutation Update and Keystream Drip Engine

This block holds the running state of a byte-oriented, sponge-style stream cipher: a 2^W-entry permutation array plus five W-bit registers (`i`, `j`, `k`, `w`, `z`). On command it advances that state, either by running the cipher's update step or by running update followed by the output step, which yields one keystream byte. All arithmetic is modulo 2^W (256 by default). One update is the following sequence: `i = i + w`, then `j = k + S[j + S[i]]`, then `k = i + k + S[j]`, and last a swap of `S[i]` with `S[j]`. The output step sets `z = S[j + S[i + S[z + k]]]`.

The update step runs in three pipeline stages. Stage one moves `i` forward and forms `j + S[i]`. Stage two forms the new `j` and the partial sum `k + i`. Stage three swaps the entries and produces the new `k`. No array read result feeds another read address in the same cycle. When updates run back to back, stage one of the next update shares a cycle with stage three of the current one. A forwarding path gives it the values after the swap, so one update issues every two cycles. A drip adds three output stages after the update, and these run alongside the first three stages of the next drip. That gives one byte every three cycles. The two-cycle gap covers the dependence of the next output on the freshly written `z`.

A single controller state machine sequences everything. Its states are `ST_IDLE`, `ST_U1`, `ST_U2`, `ST_U3`, `ST_FIN`, `ST_D1`, `ST_D2`, `ST_D3`, `ST_O4`, `ST_O5` and `ST_O6`. A start pulse in `ST_IDLE` selects one of three branches:
- update mode goes to `ST_U1`;
- whip mode with a nonzero count goes to `ST_U1`;
- drip mode with a nonzero count goes to `ST_D1`;
- a zero count in whip or drip mode goes to `ST_FIN`.

The transitions after that are fixed:
- `ST_U1` always goes to `ST_U2`.
- `ST_U2` returns to `ST_U1` in overlapped form while updates remain, and otherwise goes to `ST_U3`.
- `ST_U3` goes to `ST_FIN`.
- `ST_FIN` adds 2 to `w` if the command was a whip, then returns to `ST_IDLE`.
- `ST_D1` goes to `ST_D2`, and `ST_D2` goes to `ST_D3`.
- `ST_D3` returns to `ST_D1` in overlapped form while drips remain, and otherwise drains through `ST_O4`, `ST_O5` and `ST_O6` back to `ST_IDLE`.

Top module: `perm_step_engine`

## Requirements
- R1: At reset the array holds the identity permutation (`S[x] = x`), `i`, `j`, `k` and `z` are 0, `w` is 1, and `ks_valid_o`, `done_o` and `busy_o` are low.
- R2: Each update changes the state exactly as the update sequence above: `i += w`, `j = k + S[j + S[i]]`, `k = i + k + S[j]`, then `S[i]` and `S[j]` are swapped, all modulo 2^W.
- R3: Mode code 2'b00 (update) runs exactly one update whatever `count_i` holds, leaves `w` unchanged, emits no byte, and raises `done_o` at the 4th rising edge after the start edge.
- R4: Mode code 2'b01 (whip) with count x ≥ 1 runs x updates, then adds 2 to `w`; `done_o` rises at edge 2x+2 after the start edge and no byte is emitted.
- R5: Mode code 2'b10 (drip) with count x ≥ 1 runs x drips. Drip n (n = 1..x) presents its byte `z` on `ks_byte_o`, with `ks_valid_o` high for exactly one cycle, at edge 3n+3 after the start edge. `ks_valid_o` is low at every other time.
- R6: In drip mode `done_o` rises at edge 3x+3, in the same cycle as the last byte.
- R7: A count of zero in whip mode only adds 2 to `w`, and in drip mode changes nothing. In both cases `done_o` rises at edge 1.
- R8: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`, where it falls. `done_o` lasts one cycle. A start pulse seen while busy is ignored.
- R9: Mode code 2'b11 behaves exactly as drip mode, because bit 1 of the mode selects drip.
- R10: Overlapped back-to-back updates, with forwarding of the swapped entries into the next update's first stage, give the same state as the same updates run one at a time. This holds for long whips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe, accepted only while idle |
| mode_i | input | 2 | 00 update, 01 whip, 1x drip |
| count_i | input | CW (16) | Number of updates (whip) or bytes (drip) |
| ks_byte_o | output | W (8) | Keystream byte |
| ks_valid_o | output | 1 | One-cycle strobe qualifying `ks_byte_o` |
| done_o | output | 1 | One-cycle pulse at command completion |
| busy_o | output | 1 | High while a command is in progress |

## Verification
All result timings are counted in rising edges after the edge that samples the start pulse (edge 0):
- drip byte n is due at edge 3n+3;
- a whip of x updates completes at edge 2x+2;
- a single update completes at edge 4;
- a zero-count command completes at edge 1.

Inputs change on falling edges, and the outputs are sampled on the falling edge after each rising edge. At every such sample the bench compares `ks_valid_o`, `done_o` and `busy_o` against the schedule above, and compares the byte against a behavioural model run in plain integer arithmetic. Effects on the state that the ports cannot show directly (updates, whips, the `w` step) are checked through the drip bytes that follow them.

// File: rtl/perm_step_pkg.sv
package perm_step_pkg;

    // Controller states: U* run update stages, D* run drip stages
    // (overlapping the previous drip's output stages), O* drain output.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_U3,
        ST_FIN,
        ST_D1,
        ST_D2,
        ST_D3,
        ST_O4,
        ST_O5,
        ST_O6
    } pse_state_t;

    // Mode decoding: bit 1 selects drip, otherwise 2'b01 is whip.
    localparam int         MODE_DRIP_BIT = 1;
    localparam logic [1:0] MODE_WHIP     = 2'b01;

    // Read ports of the state array.
    localparam int RP_S1  = 0;  // S[i + w]
    localparam int RP_S2  = 1;  // S[t1]
    localparam int RP_SI  = 2;  // S[i]
    localparam int RP_SJ  = 3;  // S[j]
    localparam int RP_S4  = 4;  // S[z + k]
    localparam int RP_S5  = 5;  // S[t6]
    localparam int RP_S6  = 6;  // S[t7]
    localparam int RP_NUM = 7;

endpackage

// File: rtl/perm_step_array.sv
module perm_step_array #(
    parameter int W   = 8,
    parameter int NRD = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][W-1:0]   rd_addr,
    output logic [NRD-1:0][W-1:0]   rd_data,
    input  logic                    swap_en,
    input  logic [W-1:0]            swap_a,
    input  logic [W-1:0]            swap_b
);
    localparam int N = 1 << W;

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int x = 0; x < N; x++) begin
                mem[x] <= W'(x);
            end
        end else if (swap_en) begin
            mem[swap_a] <= mem[swap_b];
            mem[swap_b] <= mem[swap_a];
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = mem[rd_addr[g]];
    end

endmodule

// File: rtl/perm_step_ctrl.sv
module perm_step_ctrl
    import perm_step_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] count,
    output logic          s1_en,
    output logic          s2_en,
    output logic          s3_en,
    output logic          s4_en,
    output logic          s5_en,
    output logic          s6_en,
    output logic          w_bump,
    output logic          busy,
    output logic          done
);
    pse_state_t    state, nxt;
    logic [CW-1:0] rem, rem_n;
    logic          ovl, ovl_n;
    logic          whp, whp_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
            ovl   <= 1'b0;
            whp   <= 1'b0;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            rem   <= rem_n;
            ovl   <= ovl_n;
            whp   <= whp_n;
            done  <= (state == ST_FIN) || (state == ST_O6);
        end
    end

    // Next state.
    always_comb begin
        nxt   = state;
        rem_n = rem;
        ovl_n = ovl;
        whp_n = whp;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ovl_n = 1'b0;
                    if (mode[MODE_DRIP_BIT]) begin
                        whp_n = 1'b0;
                        if (count == '0) begin
                            nxt = ST_FIN;
                        end else begin
                            nxt   = ST_D1;
                            rem_n = count - CW'(1);
                        end
                    end else if (mode == MODE_WHIP) begin
                        whp_n = 1'b1;
                        if (count == '0) begin
                            nxt = ST_FIN;
                        end else begin
                            nxt   = ST_U1;
                            rem_n = count - CW'(1);
                        end
                    end else begin
                        whp_n = 1'b0;
                        nxt   = ST_U1;
                        rem_n = '0;
                    end
                end
            end
            ST_U1: nxt = ST_U2;
            ST_U2: begin
                if (rem != '0) begin
                    rem_n = rem - CW'(1);
                    ovl_n = 1'b1;
                    nxt   = ST_U1;
                end else begin
                    nxt = ST_U3;
                end
            end
            ST_U3:  nxt = ST_FIN;
            ST_FIN: nxt = ST_IDLE;
            ST_D1:  nxt = ST_D2;
            ST_D2:  nxt = ST_D3;
            ST_D3: begin
                if (rem != '0) begin
                    rem_n = rem - CW'(1);
                    ovl_n = 1'b1;
                    nxt   = ST_D1;
                end else begin
                    nxt = ST_O4;
                end
            end
            ST_O4:  nxt = ST_O5;
            ST_O5:  nxt = ST_O6;
            ST_O6:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Stage enables.
    always_comb begin
        s1_en  = 1'b0;
        s2_en  = 1'b0;
        s3_en  = 1'b0;
        s4_en  = 1'b0;
        s5_en  = 1'b0;
        s6_en  = 1'b0;
        w_bump = 1'b0;
        busy   = (state != ST_IDLE);
        unique case (state)
            ST_U1: begin s1_en = 1'b1; s3_en = ovl; end
            ST_U2: s2_en = 1'b1;
            ST_U3: s3_en = 1'b1;
            ST_FIN: w_bump = whp;
            ST_D1: begin s1_en = 1'b1; s4_en = ovl; end
            ST_D2: begin s2_en = 1'b1; s5_en = ovl; end
            ST_D3: begin s3_en = 1'b1; s6_en = ovl; end
            ST_O4: s4_en = 1'b1;
            ST_O5: s5_en = 1'b1;
            ST_O6: s6_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/perm_step_engine.sv
module perm_step_engine
    import perm_step_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] count_i,
    output logic [W-1:0]  ks_byte_o,
    output logic          ks_valid_o,
    output logic          done_o,
    output logic          busy_o
);
    logic s1_en, s2_en, s3_en, s4_en, s5_en, s6_en, w_bump;

    logic [W-1:0] ri, rj, rk, rw, rz;
    logic [W-1:0] t1, t3, t6, t7;
    logic [RP_NUM-1:0][W-1:0] rd_addr, rd_data;
    logic [W-1:0] s1_addr, s1_val;

    perm_step_ctrl #(.CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .mode   (mode_i),
        .count  (count_i),
        .s1_en  (s1_en),
        .s2_en  (s2_en),
        .s3_en  (s3_en),
        .s4_en  (s4_en),
        .s5_en  (s5_en),
        .s6_en  (s6_en),
        .w_bump (w_bump),
        .busy   (busy_o),
        .done   (done_o)
    );

    perm_step_array #(.W(W), .NRD(RP_NUM)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .swap_en (s3_en),
        .swap_a  (ri),
        .swap_b  (rj)
    );

    assign s1_addr        = ri + rw;
    assign rd_addr[RP_S1] = s1_addr;
    assign rd_addr[RP_S2] = t1;
    assign rd_addr[RP_SI] = ri;
    assign rd_addr[RP_SJ] = rj;
    assign rd_addr[RP_S4] = rz + rk;
    assign rd_addr[RP_S5] = t6;
    assign rd_addr[RP_S6] = t7;

    // Stage 1 shares a cycle with the previous stage 3: forward the swap.
    always_comb begin
        if (s3_en && (s1_addr == ri)) begin
            s1_val = rd_data[RP_SJ];
        end else if (s3_en && (s1_addr == rj)) begin
            s1_val = rd_data[RP_SI];
        end else begin
            s1_val = rd_data[RP_S1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ri         <= '0;
            rj         <= '0;
            rk         <= '0;
            rw         <= W'(1);
            rz         <= '0;
            t1         <= '0;
            t3         <= '0;
            t6         <= '0;
            t7         <= '0;
            ks_byte_o  <= '0;
            ks_valid_o <= 1'b0;
        end else begin
            if (s1_en) begin
                ri <= s1_addr;
                t1 <= rj + s1_val;
            end
            if (s2_en) begin
                rj <= rk + rd_data[RP_S2];
                t3 <= rk + ri;
            end
            if (s3_en) begin
                rk <= t3 + rd_data[RP_SJ];
            end
            if (s4_en) begin
                t6 <= ri + rd_data[RP_S4];
            end
            if (s5_en) begin
                t7 <= rj + rd_data[RP_S5];
            end
            if (s6_en) begin
                rz        <= rd_data[RP_S6];
                ks_byte_o <= rd_data[RP_S6];
            end
            if (w_bump) begin
                rw <= rw + W'(2);
            end
            ks_valid_o <= s6_en;
        end
    end

endmodule

// File: rtl/perm_step_engine_chk.sv
module perm_step_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ks_valid_o,
    input logic done_o,
    input logic busy_o
);
    AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |=> !ks_valid_o); // R5

    AST_BYTE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid_o |-> $past(busy_o)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R8

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8

endmodule

bind perm_step_engine perm_step_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ks_valid_o (ks_valid_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
);

// File: tb/perm_step_engine_tb.sv
module perm_step_engine_tb;
    localparam int W  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [CW-1:0] count_i = '0;
    logic [W-1:0]  ks_byte_o;
    logic          ks_valid_o, done_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Behavioural model state.
    int ms[256];
    int mi, mj, mk, mw, mz;
    int exp_q[$];

    always #10 clk = ~clk;

    perm_step_engine #(.W(W), .CW(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .count_i    (count_i),
        .ks_byte_o  (ks_byte_o),
        .ks_valid_o (ks_valid_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic m_update();
        int tmp;
        mi = (mi + mw) & 255;
        mj = (mk + ms[(mj + ms[mi]) & 255]) & 255;
        mk = (mi + mk + ms[mj]) & 255;
        tmp = ms[mi];
        ms[mi] = ms[mj];
        ms[mj] = tmp;
    endtask

    task automatic m_drip();
        m_update();
        mz = ms[(mj + ms[(mi + ms[(mz + mk) & 255]) & 255]) & 255];
        exp_q.push_back(mz);
    endtask

    // Issue one command and compare the ports at every cycle until done.
    task automatic run_op(input logic [1:0] md, input int cnt, input int poke,
                          input string tag);
        int kend;
        bit drip;
        drip = md[1];
        if (drip) begin
            for (int n = 0; n < cnt; n++) m_drip();
            kend = (cnt == 0) ? 1 : 3 * cnt + 3;
        end else if (md == 2'b01) begin
            for (int n = 0; n < cnt; n++) m_update();
            mw = (mw + 2) & 255;
            kend = (cnt == 0) ? 1 : 2 * cnt + 2;
        end else begin
            m_update();
            kend = 4;
        end
        start_i = 1'b1;
        mode_i  = md;
        count_i = CW'(cnt);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= kend; k++) begin
            bit ev;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            ev = drip && (k % 3 == 0) && (k >= 6) && ((k / 3 - 1) <= cnt);
            chk(ks_valid_o == ev, tag, "ks_valid_o", int'(ks_valid_o), int'(ev));
            if (ev && ks_valid_o) begin
                int eb;
                eb = exp_q.pop_front();
                chk(int'(ks_byte_o) == eb, tag, "ks_byte_o", int'(ks_byte_o), eb);
            end
            chk(done_o == (k == kend), drip ? "R6" : tag, "done_o",
                int'(done_o), int'(k == kend));
            chk(busy_o == (k != kend), "R8", "busy_o", int'(busy_o), int'(k != kend));
            if (k == poke) begin
                // R8: a start while busy must be ignored
                start_i = 1'b1;
                mode_i  = 2'b10;
                count_i = CW'(5);
            end
        end
        start_i = 1'b0;
        exp_q.delete();
    endtask

    initial begin
        for (int x = 0; x < 256; x++) ms[x] = x;
        mi = 0; mj = 0; mk = 0; mw = 1; mz = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!ks_valid_o && !done_o && !busy_o, "R1", "idle outputs in reset",
            int'({ks_valid_o, done_o, busy_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ks_valid_o && !done_o && !busy_o, "R1", "idle outputs after reset",
            int'({ks_valid_o, done_o, busy_o}), 0);

        run_op(2'b10, 3, 0, "R1");     // keystream straight from reset state
        run_op(2'b00, 7, 0, "R3");     // single update, count ignored
        run_op(2'b10, 2, 0, "R2");     // bytes reveal the updated state
        run_op(2'b01, 4, 0, "R4");     // whip
        run_op(2'b10, 4, 0, "R4");
        run_op(2'b01, 0, 0, "R7");     // zero-count whip: w step only
        run_op(2'b10, 2, 0, "R7");
        run_op(2'b10, 0, 0, "R7");     // zero-count drip: nothing
        run_op(2'b10, 1, 0, "R7");
        run_op(2'b11, 2, 0, "R9");     // 2'b11 acts as drip
        run_op(2'b01, 3, 2, "R8");     // start while busy is ignored
        run_op(2'b10, 2, 0, "R8");
        run_op(2'b01, 40, 0, "R10");   // long overlapped whip
        run_op(2'b10, 8, 0, "R10");
        run_op(2'b00, 0, 0, "R3");
        run_op(2'b10, 5, 0, "R5");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule